// File: doc/BRIEF.md
# Shader General Register File

This block holds the untyped 32-bit working registers of a shader core. There are 255 general registers, at indices 0 to 254. Index 255 is a hardwired zero register: any read of it returns zero, and any write to it is discarded. The storage has no type. The instructions that consume a word decide whether it is an integer, a float, a pair of halves or one half of a double.

Two read ports and one write port each work on a run of consecutive registers. A run has a base index and a count of 1 to 4 words, which covers 64-bit operands, coordinate pairs and multi-component results. On every port, word slot k carries register base+k, so a 64-bit read at base Ra puts Ra in slot 0 (the low word) and Ra+1 in slot 1 (the high word). Reads are combinational. A write takes effect at the clock edge.

Top module: `sgrf_regfile`

## Requirements
- R1: After reset every general register (0 to 254) reads as zero.
- R2: A read returns the run in ascending index order: bits [32k+31:32k] of the read data hold register base+k, so slot 0 is the low word of a 64-bit operand and slot 1 is its high word.
- R3: Only the first N slots of a read carry data, where N is the count, and the remaining slots read as zero. A count of 0 returns all zeros, and counts 5 to 7 act as 4.
- R4: A read slot whose index (base+k) is 255 or above reads as zero. This includes a direct read of register 255.
- R5: With the write enable high, slot k of the write data (bits [32k+31:32k]) is stored into register base+k for each k below the effective count, using the same count rules as reads. A count of 0 stores nothing.
- R6: A write element whose index is 255 or above is dropped. Register 255 keeps no state, and indices do not wrap around to register 0.
- R7: A write becomes visible to reads on the cycle after its clock edge. A read in the same cycle as the write returns the old value.
- R8: While the write enable is low, no register changes, whatever the other write inputs hold.
- R9: The two read ports are independent. Each port may address any run, and both ports may address the same registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| rd0_base | input | 8 | Read port 0 base index |
| rd0_cnt | input | 3 | Read port 0 word count (0 to 7; values above 4 act as 4) |
| rd0_data | output | 128 | Read port 0 words; slot k in bits [32k+31:32k] |
| rd1_base | input | 8 | Read port 1 base index |
| rd1_cnt | input | 3 | Read port 1 word count |
| rd1_data | output | 128 | Read port 1 words |
| wr_en | input | 1 | Write enable |
| wr_base | input | 8 | Write base index |
| wr_cnt | input | 3 | Write word count |
| wr_data | input | 128 | Write words; slot k goes to base+k |

## Verification
The bench first sweeps every register after reset. Directed runs then separate correct slot ordering from reversed or shifted ordering, and they test each count from 0 to 7 to expose slots that are not masked. Runs that start at 252 and 253 cross the zero-register boundary: they show whether out-of-range elements read as zero and whether writes are dropped or wrap around to register 0. A write followed by a read of the same index in the same cycle, and then in the next cycle, separates a registered write from a bypassed one. A long stretch of random traffic on all three ports, weighted toward the top indices, is then compared against a behavioural model on every clock.

// File: rtl/sgrf_pkg.sv
package sgrf_pkg;

   // Effective run length: a count is clamped to the number of slots.
   function automatic int run_len(input int cnt, input int max_run);
      return (cnt > max_run) ? max_run : cnt;
   endfunction

endpackage

// File: rtl/sgrf_store.sv
module sgrf_store #(
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 255,
   parameter int MAX_RUN  = 4,
   parameter int IDX_W    = 8,
   parameter int CNT_W    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_base,
   input  logic [CNT_W-1:0]            wr_cnt,
   input  logic [MAX_RUN*WORD_W-1:0]   wr_data,
   output logic [NUM_REGS*WORD_W-1:0]  regs_flat
);
   import sgrf_pkg::*;

   localparam int SUM_W = IDX_W + 1;

   logic [WORD_W-1:0] mem [NUM_REGS];
   int                wr_len;

   assign wr_len = run_len(int'(wr_cnt), MAX_RUN);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic              hit;
      logic [WORD_W-1:0] din;

      always_comb begin
         hit = 1'b0;
         din = '0;
         for (int k = 0; k < MAX_RUN; k++) begin
            if (wr_en && (k < wr_len) &&
                (({1'b0, wr_base} + SUM_W'(k)) == SUM_W'(r))) begin
               hit = 1'b1;
               din = wr_data[k*WORD_W +: WORD_W];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   mem[r] <= '0;
         else if (hit) mem[r] <= din;
      end

      assign regs_flat[r*WORD_W +: WORD_W] = mem[r];
   end

   // R5: the first word of an enabled write lands in its base register
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_cnt != '0 && int'(wr_base) < NUM_REGS)
      |=> mem[$past(wr_base)] == $past(wr_data[WORD_W-1:0]));

   // R8: no register moves while the write enable is low
   p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_flat));

endmodule

// File: rtl/sgrf_read_port.sv
module sgrf_read_port #(
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 255,
   parameter int MAX_RUN  = 4,
   parameter int IDX_W    = 8,
   parameter int CNT_W    = 3
) (
   input  logic [NUM_REGS*WORD_W-1:0] regs_flat,
   input  logic [IDX_W-1:0]           base,
   input  logic [CNT_W-1:0]           cnt,
   output logic [MAX_RUN*WORD_W-1:0]  data
);
   import sgrf_pkg::*;

   localparam int SUM_W = IDX_W + 1;

   int rd_len;
   assign rd_len = run_len(int'(cnt), MAX_RUN);

   for (genvar k = 0; k < MAX_RUN; k++) begin : g_slot
      logic [SUM_W-1:0] idx;
      logic             live;
      int               pick;

      assign idx  = {1'b0, base} + SUM_W'(k);
      assign live = (k < rd_len) && (int'(idx) < NUM_REGS);
      assign pick = live ? int'(idx) : 0;
      assign data[k*WORD_W +: WORD_W] =
         live ? regs_flat[pick*WORD_W +: WORD_W] : '0;
   end

endmodule

// File: rtl/sgrf_regfile.sv
module sgrf_regfile #(
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 255,
   parameter int MAX_RUN  = 4,
   parameter int IDX_W    = 8,
   parameter int CNT_W    = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [IDX_W-1:0]           rd0_base,
   input  logic [CNT_W-1:0]           rd0_cnt,
   output logic [MAX_RUN*WORD_W-1:0]  rd0_data,
   input  logic [IDX_W-1:0]           rd1_base,
   input  logic [CNT_W-1:0]           rd1_cnt,
   output logic [MAX_RUN*WORD_W-1:0]  rd1_data,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_base,
   input  logic [CNT_W-1:0]           wr_cnt,
   input  logic [MAX_RUN*WORD_W-1:0]  wr_data
);
   localparam int NUM_RD   = 2;
   localparam int ZERO_IDX = NUM_REGS;
   localparam int RUN_W    = MAX_RUN * WORD_W;

   if (NUM_REGS >= (1 << IDX_W)) begin : g_bad_idx
      $error("index width too small for the zero register");
   end
   if ((1 << CNT_W) <= MAX_RUN) begin : g_bad_cnt
      $error("count width cannot express the longest run");
   end
   if (WORD_W < 1 || MAX_RUN < 1) begin : g_bad_shape
      $error("word width and run length must be positive");
   end

   logic [NUM_REGS*WORD_W-1:0] regs_flat;
   logic [IDX_W-1:0]           rbase [NUM_RD];
   logic [CNT_W-1:0]           rcnt  [NUM_RD];
   logic [RUN_W-1:0]           rdata [NUM_RD];

   assign rbase[0] = rd0_base;
   assign rbase[1] = rd1_base;
   assign rcnt[0]  = rd0_cnt;
   assign rcnt[1]  = rd1_cnt;
   assign rd0_data = rdata[0];
   assign rd1_data = rdata[1];

   sgrf_store #(
      .WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .MAX_RUN(MAX_RUN),
      .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_base(wr_base),
      .wr_cnt(wr_cnt), .wr_data(wr_data), .regs_flat(regs_flat)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      sgrf_read_port #(
         .WORD_W(WORD_W), .NUM_REGS(NUM_REGS), .MAX_RUN(MAX_RUN),
         .IDX_W(IDX_W), .CNT_W(CNT_W)
      ) i_port (
         .regs_flat(regs_flat), .base(rbase[p]), .cnt(rcnt[p]),
         .data(rdata[p])
      );
   end

   // R4: the zero register reads as zero on either port
   p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd0_base) == ZERO_IDX || int'(rd1_base) == ZERO_IDX) |->
      ((int'(rd0_base) != ZERO_IDX || rd0_data[WORD_W-1:0] == '0) &&
       (int'(rd1_base) != ZERO_IDX || rd1_data[WORD_W-1:0] == '0)));

   // R3: a single-word read leaves the upper slots at zero
   p_tail_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_cnt == CNT_W'(1)) |-> (rd0_data[RUN_W-1:WORD_W] == '0));

   // R9: two ports on the same run see the same words
   p_ports_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_base == rd1_base && rd0_cnt == rd1_cnt) |-> (rd0_data == rd1_data));

   // R7: a written word shows on the next cycle's read of its index
   p_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en) && $past(wr_cnt) != '0 && int'($past(wr_base)) < NUM_REGS &&
       rd0_base == $past(wr_base) && rd0_cnt != '0)
      |-> (rd0_data[WORD_W-1:0] == $past(wr_data[WORD_W-1:0])));

   // R8: with no write and steady addresses, read data holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!wr_en) && $stable(rd1_base) && $stable(rd1_cnt))
      |-> $stable(rd1_data));

endmodule

// File: tb/test_sgrf_regfile.sv
`timescale 1ns/1ps
module test_sgrf_regfile;
   localparam int W  = 32;
   localparam int N  = 255;
   localparam int IW = 8;
   localparam int R  = 4;
   localparam int CW = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic [IW-1:0]   rd0_base, rd1_base, wr_base;
   logic [CW-1:0]   rd0_cnt, rd1_cnt, wr_cnt;
   logic [R*W-1:0]  rd0_data, rd1_data, wr_data;
   logic            wr_en;

   int checks = 0;
   int failures = 0;
   logic [W-1:0] model [N];

   sgrf_regfile i_sgrf_regfile (
      .clk(clk), .rst_n(rst_n),
      .rd0_base(rd0_base), .rd0_cnt(rd0_cnt), .rd0_data(rd0_data),
      .rd1_base(rd1_base), .rd1_cnt(rd1_cnt), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_base(wr_base), .wr_cnt(wr_cnt), .wr_data(wr_data)
   );

   function automatic logic [R*W-1:0] expect_read(logic [IW-1:0] b, logic [CW-1:0] c);
      logic [R*W-1:0] v = '0;
      int e = (int'(c) > R) ? R : int'(c);
      for (int k = 0; k < R; k++)
         if (k < e && int'(b) + k < N) v[k*W +: W] = model[int'(b) + k];
      return v;
   endfunction

   task automatic check_port(string tag, int port, logic [IW-1:0] b, logic [CW-1:0] c,
                             logic [R*W-1:0] act, logic [R*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s port%0d base=%0d cnt=%0d actual=%h expected=%h",
                  tag, port, b, c, act, exp);
      end
   endtask

   // Called just after a falling edge; drives, checks, crosses one rising edge.
   task automatic step(string tag, logic we, logic [IW-1:0] wb, logic [CW-1:0] wc,
                       logic [R*W-1:0] wd, logic [IW-1:0] b0, logic [CW-1:0] c0,
                       logic [IW-1:0] b1, logic [CW-1:0] c1);
      int e;
      wr_en = we; wr_base = wb; wr_cnt = wc; wr_data = wd;
      rd0_base = b0; rd0_cnt = c0; rd1_base = b1; rd1_cnt = c1;
      #1;
      check_port(tag, 0, b0, c0, rd0_data, expect_read(b0, c0));
      check_port(tag, 1, b1, c1, rd1_data, expect_read(b1, c1));
      @(posedge clk);
      if (we) begin
         e = (int'(wc) > R) ? R : int'(wc);
         for (int k = 0; k < e; k++)
            if (int'(wb) + k < N) model[int'(wb) + k] = wd[k*W +: W];
      end
      @(negedge clk);
   endtask

   function automatic logic [R*W-1:0] pattern(int seed);
      logic [R*W-1:0] v;
      for (int k = 0; k < R; k++) v[k*W +: W] = 32'hC0DE_0000 ^ (seed * 16 + k + 1);
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_base = '0; wr_cnt = '0; wr_data = '0;
      rd0_base = '0; rd0_cnt = '0; rd1_base = '0; rd1_cnt = '0;
      for (int i = 0; i < N; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: every register reads zero after reset
      for (int b = 0; b < N; b += 8)
         step("R1", 1'b0, '0, '0, '0, IW'(b), 3'd4, IW'(b + 4), 3'd4);

      // R7: same-cycle read sees old value, next cycle sees new
      step("R7", 1'b1, 8'd20, 3'd1, pattern(1), 8'd20, 3'd1, 8'd20, 3'd1);
      step("R7", 1'b0, '0, '0, '0, 8'd20, 3'd1, 8'd19, 3'd2);

      // R2: 64-bit pair and four-word run in ascending order
      step("R5", 1'b1, 8'd10, 3'd2, pattern(2), 8'd0, 3'd0, 8'd0, 3'd0);
      step("R2", 1'b1, 8'd30, 3'd4, pattern(3), 8'd10, 3'd2, 8'd11, 3'd1);
      step("R2", 1'b0, '0, '0, '0, 8'd30, 3'd4, 8'd31, 3'd2);

      // R3: slot masking by count, including 0 and counts above 4
      for (int c = 0; c < 8; c++)
         step("R3", 1'b0, '0, '0, '0, 8'd30, CW'(c), 8'd29, CW'(7 - c));

      // R5: a count of 0 stores nothing
      step("R5", 1'b1, 8'd40, 3'd0, pattern(4), 8'd40, 3'd4, 8'd0, 3'd0);
      step("R5", 1'b0, '0, '0, '0, 8'd40, 3'd4, 8'd40, 3'd1);

      // R6: writes crossing the top are dropped and do not wrap
      step("R6", 1'b1, 8'd0, 3'd2, pattern(5), 8'd0, 3'd0, 8'd0, 3'd0);
      step("R6", 1'b1, 8'd253, 3'd4, pattern(6), 8'd0, 3'd2, 8'd0, 3'd0);
      step("R6", 1'b1, 8'd255, 3'd3, pattern(7), 8'd252, 3'd4, 8'd0, 3'd2);
      step("R6", 1'b0, '0, '0, '0, 8'd255, 3'd4, 8'd0, 3'd2);

      // R4: reads at or above the zero register return zero
      step("R4", 1'b0, '0, '0, '0, 8'd253, 3'd4, 8'd255, 3'd1);
      step("R4", 1'b0, '0, '0, '0, 8'd254, 3'd4, 8'd252, 3'd4);

      // R8: disabled write with live-looking inputs changes nothing
      step("R8", 1'b0, 8'd30, 3'd4, pattern(8), 8'd30, 3'd4, 8'd10, 3'd2);
      step("R8", 1'b0, '0, '0, '0, 8'd30, 3'd4, 8'd32, 3'd2);

      // R9: random traffic on all ports, biased toward the top indices
      for (int i = 0; i < 3000; i++) begin
         logic [IW-1:0] wb, b0, b1;
         wb = ($urandom % 4 == 0) ? IW'(248 + $urandom % 8) : IW'($urandom);
         b0 = ($urandom % 4 == 0) ? IW'(248 + $urandom % 8) : IW'($urandom % 64 + (wb & 8'hC0));
         b1 = ($urandom % 3 == 0) ? b0 : IW'($urandom);
         step("R9", 1'($urandom), wb, CW'($urandom), {$urandom, $urandom, $urandom, $urandom},
              b0, CW'($urandom), b1, CW'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule